// File: doc/BRIEF.md
# Coherence Message Dispatch Scheduler

This block chooses which pending coherence message the protocol engine services next. Seven input sources compete: the main processor-interface queue, a processor-interface bypass queue, four network input lanes (one per virtual lane Q0..Q3) and a software overflow queue. Sources are visited in rotating order. A source that holds a message is only eligible when every outgoing virtual lane it might write into has at least a minimum number of free slots. This keeps the protocol engine from starting a handler that could stall on a full output queue.

Which outgoing lanes each source depends on is held in a small dependence table. The table starts with the baseline dependences at reset and can be rewritten at boot through a simple write port. Free space per outgoing lane is tracked inside the block by one up/down credit counter per lane. An enqueue into a lane spends a slot and a drain returns one. The grant is combinational from the current inputs and registered state. Its result is produced in the same cycle as a one-hot vector and as an index.

Top module: `dispatch_sched`

## Requirements
- R1: After reset every lane reports LANE_DEPTH (default 16) free slots, the rotation pointer is at source 0, the dependence table holds the baseline masks, and no grant is raised while no source is valid.
- R2: A source is granted only if its `src_valid` bit is set and every lane whose bit is set in its mask has at least MIN_FREE (default 2) free slots. Mask bit i stands for lane Qi.
- R3: The grant goes to the first eligible source found scanning upward from the rotation pointer with wraparound after source 6. After a grant the pointer becomes the granted index plus one, with 6 wrapping to 0. With no grant the pointer holds its value.
- R4: A valid source that lacks credits is passed over without moving the pointer past it on its own account. A source with an all-zero mask is eligible whenever it is valid, regardless of lane credits.
- R5: In one cycle, an enqueue alone on a lane lowers its free count by one, a drain alone raises it by one, and both together leave it unchanged.
- R6: An enqueue on a lane with zero free slots is ignored. A drain on a lane already at LANE_DEPTH free slots is ignored.
- R7: A table write with `cfg_we` high replaces the mask of source `cfg_src` from the next cycle on. A write whose index is 7 or more changes no mask.
- R8: `grant` has at most one bit set. `grant_valid` equals the OR of `grant`. `grant_idx` is the index of the set bit, or 0 when there is none.
- R9: The baseline masks are as follows. Source 0 (processor main) has 4'b0101. Source 1 (processor bypass) has 4'b0011. Source 2 (network Q0) has 4'b0110. Source 3 (network Q1, the sink) has 4'b0000. Source 4 (network Q2) has 4'b0010. Source 5 (network Q3) has 4'b0000. Source 6 (software queue) has 4'b0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Dependence table write strobe |
| cfg_src | input | 3 | Source index whose mask is written |
| cfg_mask | input | 4 | New lane mask, bit i = lane Qi |
| src_valid | input | 7 | Per-source not-empty flags |
| lane_enq | input | 4 | Per-lane enqueue into an outgoing lane (spends a slot) |
| lane_deq | input | 4 | Per-lane drain from an outgoing lane (returns a slot) |
| grant | output | 7 | One-hot grant to the selected source |
| grant_idx | output | 3 | Index of the granted source |
| grant_valid | output | 1 | A grant is issued this cycle |
| lane_free | output | 20 | Free-slot count per lane, 5 bits each, lane 0 in the low bits |

## Verification
The rotation is first tried with every source valid and all credits present, so that each grant can only come from the pointer order. Then single lanes are starved below the threshold while their dependent sources stay valid. This separates a correct skip from both a stuck pointer and a grant that ignores credits. Enqueue and drain are pulsed together, and at the empty and full limits, so that the counter step is told apart from the saturation rule. Long random phases mix valid patterns, table rewrites (including out-of-range indices) and enqueue-heavy and drain-heavy traffic, and a bench model predicts each grant and count.

// File: rtl/dsched_pkg.sv
package dsched_pkg;

    localparam int SRC_N  = 7;
    localparam int LANE_N = 4;
    localparam int SRC_W  = $clog2(SRC_N);

    typedef enum logic [SRC_W-1:0] {
        SRC_PI_MAIN = 3'd0,
        SRC_PI_BYP  = 3'd1,
        SRC_NET_Q0  = 3'd2,
        SRC_NET_Q1  = 3'd3,
        SRC_NET_Q2  = 3'd4,
        SRC_NET_Q3  = 3'd5,
        SRC_SWQ     = 3'd6
    } src_e;

    // Baseline lane dependences loaded at reset (bit i = lane Qi).
    function automatic logic [LANE_N-1:0] boot_mask(input int s);
        logic [LANE_N-1:0] m;
        case (s)
            int'(SRC_PI_MAIN): m = 4'b0101;
            int'(SRC_PI_BYP):  m = 4'b0011;
            int'(SRC_NET_Q0):  m = 4'b0110;
            int'(SRC_NET_Q1):  m = 4'b0000;
            int'(SRC_NET_Q2):  m = 4'b0010;
            int'(SRC_NET_Q3):  m = 4'b0000;
            int'(SRC_SWQ):     m = 4'b0100;
            default:           m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dsched_credit.sv
module dsched_credit
    import dsched_pkg::*;
#(
    parameter int LANE_DEPTH = 16,
    parameter int CNT_W      = $clog2(LANE_DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANE_N-1:0]             lane_enq,
    input  logic [LANE_N-1:0]             lane_deq,
    output logic [LANE_N-1:0][CNT_W-1:0]  free_cnt
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(LANE_DEPTH);

    typedef struct packed {
        logic [LANE_N-1:0][CNT_W-1:0] free;
    } crd_st_t;

    crd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int l = 0; l < LANE_N; l++) begin
            logic take, give;
            take = lane_enq[l] && (st_q.free[l] != '0);
            give = lane_deq[l] && (st_q.free[l] != FULL);
            case ({take, give})
                2'b10:   st_d.free[l] = st_q.free[l] - 1'b1;
                2'b01:   st_d.free[l] = st_q.free[l] + 1'b1;
                default: st_d.free[l] = st_q.free[l];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < LANE_N; l++) st_q.free[l] <= FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign free_cnt = st_q.free;

    for (genvar g = 0; g < LANE_N; g++) begin : g_chk
        AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.free[g] <= FULL);  // R6
        AST_CREDIT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_enq[g] && !lane_deq[g] && st_q.free[g] != '0)
            |=> st_q.free[g] == $past(st_q.free[g]) - 1'b1);  // R5
        AST_CREDIT_INC: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_deq[g] && !lane_enq[g] && st_q.free[g] != FULL)
            |=> st_q.free[g] == $past(st_q.free[g]) + 1'b1);  // R5
        AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_enq[g] && !lane_deq[g] && st_q.free[g] == '0)
            |=> st_q.free[g] == '0);  // R6
    end

endmodule

// File: rtl/dsched_dep_table.sv
module dsched_dep_table
    import dsched_pkg::*;
#(
    parameter int MIN_FREE = 2,
    parameter int CNT_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [SRC_W-1:0]              cfg_src,
    input  logic [LANE_N-1:0]             cfg_mask,
    input  logic [SRC_N-1:0]              src_valid,
    input  logic [LANE_N-1:0][CNT_W-1:0]  free_cnt,
    output logic [SRC_N-1:0]              eligible
);

    localparam logic [CNT_W-1:0] THRESH = CNT_W'(MIN_FREE);

    typedef struct packed {
        logic [SRC_N-1:0][LANE_N-1:0] mask;
    } dep_st_t;

    dep_st_t           st_d, st_q;
    logic [LANE_N-1:0] lane_ok;

    always_comb begin
        st_d = st_q;
        if (cfg_we && (int'(cfg_src) < SRC_N)) begin
            st_d.mask[cfg_src] = cfg_mask;
        end
        for (int l = 0; l < LANE_N; l++) begin
            lane_ok[l] = (free_cnt[l] >= THRESH);
        end
        for (int s = 0; s < SRC_N; s++) begin
            eligible[s] = src_valid[s] && ((st_q.mask[s] & ~lane_ok) == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SRC_N; s++) st_q.mask[s] <= boot_mask(s);
        end else begin
            st_q <= st_d;
        end
    end

    AST_CFG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && int'(cfg_src) >= SRC_N) |=> $stable(st_q.mask));  // R7
    AST_CFG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(st_q.mask));  // R7

endmodule

// File: rtl/dsched_rr_arb.sv
module dsched_rr_arb
    import dsched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  eligible,
    output logic [SRC_N-1:0]  grant,
    output logic [SRC_W-1:0]  grant_idx,
    output logic              grant_valid
);

    localparam logic [SRC_W:0]   SRC_N_W = (SRC_W+1)'(SRC_N);
    localparam logic [SRC_W-1:0] LAST    = SRC_W'(SRC_N - 1);

    typedef struct packed {
        logic [SRC_W-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        logic [SRC_W:0]   idx;
        logic             found;
        logic [SRC_W-1:0] sel;
        st_d  = st_q;
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < SRC_N; k++) begin
            idx = {1'b0, st_q.ptr} + (SRC_W+1)'(k);
            if (idx >= SRC_N_W) idx = idx - SRC_N_W;
            if (!found && eligible[idx[SRC_W-1:0]]) begin
                found = 1'b1;
                sel   = idx[SRC_W-1:0];
            end
        end
        grant       = '0;
        grant_idx   = '0;
        grant_valid = found;
        if (found) begin
            grant[sel] = 1'b1;
            grant_idx  = sel;
            st_d.ptr   = (sel == LAST) ? '0 : sel + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));  // R8
    AST_GRANT_IFF_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
        (eligible != '0) == grant_valid);  // R3
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |=> $stable(st_q.ptr));  // R3
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ptr <= LAST);  // R3

endmodule

// File: rtl/dispatch_sched.sv
module dispatch_sched
    import dsched_pkg::*;
#(
    parameter int LANE_DEPTH = 16,
    parameter int MIN_FREE   = 2,
    localparam int CNT_W     = $clog2(LANE_DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SRC_W-1:0]          cfg_src,
    input  logic [LANE_N-1:0]         cfg_mask,
    input  logic [SRC_N-1:0]          src_valid,
    input  logic [LANE_N-1:0]         lane_enq,
    input  logic [LANE_N-1:0]         lane_deq,
    output logic [SRC_N-1:0]          grant,
    output logic [SRC_W-1:0]          grant_idx,
    output logic                      grant_valid,
    output logic [LANE_N*CNT_W-1:0]   lane_free
);

    logic [LANE_N-1:0][CNT_W-1:0] free_cnt;
    logic [SRC_N-1:0]             eligible;

    dsched_credit #(
        .LANE_DEPTH (LANE_DEPTH),
        .CNT_W      (CNT_W)
    ) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_enq (lane_enq),
        .lane_deq (lane_deq),
        .free_cnt (free_cnt)
    );

    dsched_dep_table #(
        .MIN_FREE (MIN_FREE),
        .CNT_W    (CNT_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_src   (cfg_src),
        .cfg_mask  (cfg_mask),
        .src_valid (src_valid),
        .free_cnt  (free_cnt),
        .eligible  (eligible)
    );

    dsched_rr_arb u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .eligible    (eligible),
        .grant       (grant),
        .grant_idx   (grant_idx),
        .grant_valid (grant_valid)
    );

    assign lane_free = free_cnt;

    AST_GRANT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~src_valid) == '0);  // R2
    AST_GRANT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid == (grant != '0));  // R8

endmodule

// File: tb/tb_dispatch_sched.sv
`timescale 1ns/1ps
module tb_dispatch_sched;

    localparam int DEPTH = 16;
    localparam int THR   = 2;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int NS    = 7;
    localparam int NL    = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [2:0]     cfg_src = '0;
    logic [3:0]     cfg_mask = '0;
    logic [6:0]     src_valid = '0;
    logic [3:0]     lane_enq = '0;
    logic [3:0]     lane_deq = '0;
    logic [6:0]     grant;
    logic [2:0]     grant_idx;
    logic           grant_valid;
    logic [NL*CW-1:0] lane_free;

    always #2 clk = ~clk;

    dispatch_sched #(.LANE_DEPTH(DEPTH), .MIN_FREE(THR)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
        .cfg_mask(cfg_mask), .src_valid(src_valid), .lane_enq(lane_enq),
        .lane_deq(lane_deq), .grant(grant), .grant_idx(grant_idx),
        .grant_valid(grant_valid), .lane_free(lane_free)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model
    int m_mask [NS];
    int m_free [NL];
    int m_ptr;

    function automatic int base_mask(int s);
        case (s)
            0: return 5;  1: return 3;  2: return 6;  3: return 0;
            4: return 2;  5: return 0;  6: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_sel(logic [6:0] v);
        for (int k = 0; k < NS; k++) begin
            int s;
            bit ok;
            s  = (m_ptr + k) % NS;
            ok = v[s];
            for (int l = 0; l < NL; l++)
                if (((m_mask[s] >> l) & 1) != 0 && m_free[l] < THR) ok = 1'b0;
            if (ok) return s;
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++) m_mask[s] = base_mask(s);
        for (int l = 0; l < NL; l++) m_free[l] = DEPTH;
        m_ptr = 0;
    endtask

    // Drive one cycle, compare, then advance the model at the edge.
    task automatic step(input logic [6:0] v, input logic [3:0] enq, input logic [3:0] deq,
                        input bit we, input int csrc, input int cmask, input string tag);
        int e;
        src_valid = v; lane_enq = enq; lane_deq = deq;
        cfg_we = we; cfg_src = 3'(csrc); cfg_mask = 4'(cmask);
        #1;
        e = exp_sel(v);
        chk(int'(grant_valid) == (e >= 0 ? 1 : 0), {tag, " grant_valid R8"}, int'(grant_valid), e >= 0 ? 1 : 0);
        chk(int'(grant) == (e >= 0 ? (1 << e) : 0), {tag, " grant"}, int'(grant), e >= 0 ? (1 << e) : 0);
        chk(int'(grant_idx) == (e >= 0 ? e : 0), {tag, " grant_idx R8"}, int'(grant_idx), e >= 0 ? e : 0);
        for (int l = 0; l < NL; l++)
            chk(int'(lane_free[l*CW +: CW]) == m_free[l], "lane_free R5 R6",
                int'(lane_free[l*CW +: CW]), m_free[l]);
        @(posedge clk);
        if (e >= 0) m_ptr = (e + 1) % NS;
        if (we && csrc < NS) m_mask[csrc] = cmask;
        for (int l = 0; l < NL; l++) begin
            bit t, g;
            t = enq[l] && m_free[l] != 0;
            g = deq[l] && m_free[l] != DEPTH;
            if (t && !g) m_free[l]--;
            else if (g && !t) m_free[l]++;
        end
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, nothing valid
        step(7'h00, 4'h0, 4'h0, 0, 0, 0, "R1 idle after reset");

        // R3: full rotation with everything valid and credits present
        for (int i = 0; i < 9; i++) step(7'h7F, 4'h0, 4'h0, 0, 0, 0, "R3 rotation");

        // R9/R4: starve Q1 to 1 slot -> bypass (src1) and Q2-in (src4) blocked
        for (int i = 0; i < 15; i++) step(7'h00, 4'b0010, 4'h0, 0, 0, 0, "R5 fill Q1");
        step(7'b0011010, 4'h0, 4'h0, 0, 0, 0, "R9 Q1 starved, sink R4");
        step(7'b0011010, 4'h0, 4'h0, 0, 0, 0, "R4 skip keeps place");
        // R5: simultaneous enqueue and drain leaves count unchanged
        step(7'b0000010, 4'b0010, 4'b0010, 0, 0, 0, "R5 enq+deq same cycle");
        step(7'b0000010, 4'h0, 4'b0010, 0, 0, 0, "R2 bypass at threshold-1");
        step(7'b0000010, 4'h0, 4'h0, 0, 0, 0, "R2 bypass at threshold");

        // R6: empty lane Q3 ignores enqueue; full lane ignores drain
        for (int i = 0; i < 18; i++) step(7'h00, 4'b1000, 4'h0, 0, 0, 0, "R6 drain Q3 to zero");
        step(7'h00, 4'b1000, 4'b0001, 0, 0, 0, "R6 enq at zero, deq at full");
        step(7'h00, 4'b1000, 4'b1000, 0, 0, 0, "R6 enq+deq at zero");

        // R7: program src6 to need Q3, out-of-range write ignored
        step(7'h00, 4'h0, 4'h0, 1, 6, 4'b1000, "R7 write src6");
        step(7'h00, 4'h0, 4'h0, 1, 7, 4'b1111, "R7 write index 7");
        step(7'b1000000, 4'h0, 4'h0, 0, 0, 0, "R7 src6 blocked by Q3");
        step(7'b1000001, 4'h0, 4'h0, 0, 0, 0, "R7 src0 unaffected by index 7");
        for (int i = 0; i < 16; i++) step(7'h00, 4'h0, 4'hF, 0, 0, 0, "R5 refill");

        // Random phases
        for (int ph = 0; ph < 12; ph++) begin
            int enq_p, deq_p;
            enq_p = (ph % 3 == 0) ? 70 : 35;
            deq_p = (ph % 3 == 1) ? 70 : 35;
            for (int i = 0; i < 400; i++) begin
                logic [3:0] e, d;
                bit we;
                for (int l = 0; l < NL; l++) begin
                    e[l] = ($urandom % 100) < enq_p;
                    d[l] = ($urandom % 100) < deq_p;
                end
                we = ($urandom % 40) == 0;
                step(7'($urandom), e, d, we, int'($urandom % 8), int'($urandom % 16), "R2 R3 random");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule